// File: doc/BRIEF.md
# Conditional Loop-Back Load Unit

This block executes one family of instructions that combine three actions: a word load through a base register, a post-increment of that base register by a small signed step, and a flag-conditioned jump back to the head of a loop. An instruction is handed over on a valid/ready stream together with its program counter, the loop address, the current base register value and the status flags. The unit then issues a single load request on a valid/ready request channel and waits for the load response. After that it presents one result bundle on a valid/ready result channel. The bundle carries the register write-backs and the next program counter.

The branch target is the loop address minus 4. A fall-through goes to the current PC plus 4. A 4-bit selector chooses among ten flag conditions or an unconditional jump. The remaining selector values are reserved: they raise an illegal flag, and no load is performed. Only one instruction is in flight at a time.

Back-pressure rules:
- `instr_ready` is high only while the unit is idle.
- A raised `mem_req_valid` stays high with a constant address until `mem_req_ready` is seen.
- The result bundle stays valid and unchanged until `res_ready` is seen.
- The load response has no ready signal. It is taken only while a response is awaited.

Top module: `loopback_load_exec`

## Requirements
- R1: The instruction word decodes as follows:
  - bits [31:24] must equal 0xF7 and bits [23:16] must equal 0xE0;
  - destination index in [15:12], base index in [11:8], step in [7:4], condition selector in [3:0].
  
  A word whose two leading bytes differ from these values, or whose selector is 0xB to 0xF, produces a result with `res_illegal`=1, no load request, both write enables low, and next PC = PC+4.
- R2: For a legal instruction, the load request address equals the base value itself, with no offset. The loaded word is returned as destination write data.
- R3: For a legal instruction, the base register is written with the base value plus the sign-extended 4-bit step. Steps 8 to 15 mean -8 to -1.
- R4: Selectors 0 to 4 take the jump under these conditions:
  - 0: N xor V
  - 1: not Z and not (N xor V)
  - 2: not (N xor V)
  - 3: Z or (N xor V)
  - 4: C
- R5: Selectors 5 to 9 take the jump under these conditions:
  - 5: not C and not Z
  - 6: not C
  - 7: C or Z
  - 8: Z
  - 9: not Z
- R6: Selector 0xA always jumps. A taken jump gives next PC = loop address - 4, with wrap-around modulo 2^32. A condition that fails gives next PC = PC + 4.
- R7: The flags, PC, loop address and base value are sampled in the cycle the instruction is accepted. Later changes on those inputs do not affect the result.
- R8: When the destination and base indices are equal, the destination write enable is low and only the incremented base is written.
- R9: The handshake follows the back-pressure rules above:
  - one instruction is in flight at a time;
  - the request is held stable until accepted, and the result is held stable until accepted;
  - a load request and a result are never valid together.
- R10: A `mem_rsp_valid` pulse arriving while no response is awaited has no effect on the result.
- R11: After reset, `instr_ready`=1, `mem_req_valid`=0 and `res_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Unit idle and accepting |
| instr_word | input | 32 | Instruction encoding |
| instr_pc | input | DATA_W | PC of the instruction |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| loop_addr | input | DATA_W | Loop address register value |
| base_val | input | DATA_W | Current value of the base register |
| mem_req_valid | output | 1 | Load request valid |
| mem_req_ready | input | 1 | Load request accepted |
| mem_req_addr | output | DATA_W | Load address |
| mem_rsp_valid | input | 1 | Load data valid |
| mem_rsp_data | input | DATA_W | Load data |
| res_valid | output | 1 | Result bundle valid |
| res_ready | input | 1 | Result bundle accepted |
| res_illegal | output | 1 | Instruction was not legal |
| res_dst_we | output | 1 | Destination write enable |
| res_dst_idx | output | 4 | Destination register index |
| res_dst_data | output | DATA_W | Loaded word |
| res_base_we | output | 1 | Base write enable |
| res_base_idx | output | 4 | Base register index |
| res_base_data | output | DATA_W | Post-incremented base |
| res_next_pc | output | DATA_W | Next program counter |

## Verification
The hardest situation to reach from the ports is showing that the branch decision and the operands come from the acceptance cycle and not from later cycles. The bench therefore inverts the flags, PC, loop address and base value right after every handshake, and holds the request and the result under varying stall lengths. Every selector, legal and reserved, is swept against all sixteen flag combinations. Spurious response pulses are injected while the request is still stalled and while the unit is idle. Aliased registers, negative steps and a zero loop address round out the corner cases.

// File: rtl/lbl_pkg.sv
package lbl_pkg;

  localparam logic [7:0] OPC_FIRST  = 8'hF7;
  localparam logic [7:0] OPC_SECOND = 8'hE0;
  localparam int         IDX_W      = 4;

  localparam logic [3:0] SEL_LT = 4'h0;
  localparam logic [3:0] SEL_GT = 4'h1;
  localparam logic [3:0] SEL_GE = 4'h2;
  localparam logic [3:0] SEL_LE = 4'h3;
  localparam logic [3:0] SEL_CS = 4'h4;
  localparam logic [3:0] SEL_HI = 4'h5;
  localparam logic [3:0] SEL_CC = 4'h6;
  localparam logic [3:0] SEL_LS = 4'h7;
  localparam logic [3:0] SEL_EQ = 4'h8;
  localparam logic [3:0] SEL_NE = 4'h9;
  localparam logic [3:0] SEL_AL = 4'hA;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } flags_t;

  typedef struct packed {
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] base;
    logic [3:0]       step;
    logic [3:0]       sel;
    logic             legal;
  } dec_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } st_e;

endpackage

// File: rtl/lbl_decode.sv
module lbl_decode
  import lbl_pkg::*;
(
  input  logic [31:0] word,
  output dec_t        dec
);
  logic opc_ok;
  logic sel_ok;

  always_comb begin
    opc_ok    = (word[31:24] == OPC_FIRST) && (word[23:16] == OPC_SECOND);
    sel_ok    = (word[3:0] <= SEL_AL);
    dec.dst   = word[15:12];
    dec.base  = word[11:8];
    dec.step  = word[7:4];
    dec.sel   = word[3:0];
    dec.legal = opc_ok && sel_ok;
  end
endmodule

// File: rtl/lbl_cond.sv
module lbl_cond
  import lbl_pkg::*;
(
  input  flags_t     flg,
  input  logic [3:0] sel,
  output logic       taken
);
  logic lt;

  always_comb begin
    lt = flg.n ^ flg.v;
    case (sel)
      SEL_LT:  taken = lt;
      SEL_GT:  taken = !flg.z && !lt;
      SEL_GE:  taken = !lt;
      SEL_LE:  taken = flg.z || lt;
      SEL_CS:  taken = flg.c;
      SEL_HI:  taken = !flg.c && !flg.z;
      SEL_CC:  taken = !flg.c;
      SEL_LS:  taken = flg.c || flg.z;
      SEL_EQ:  taken = flg.z;
      SEL_NE:  taken = !flg.z;
      SEL_AL:  taken = 1'b1;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/lbl_addr.sv
module lbl_addr #(
  parameter int DATA_W  = 32,
  parameter int PC_STEP = 4
) (
  input  logic [DATA_W-1:0] base,
  input  logic [3:0]        step,
  input  logic [DATA_W-1:0] pc,
  input  logic [DATA_W-1:0] loop_addr,
  input  logic              taken,
  input  logic              legal,
  output logic [DATA_W-1:0] inc_addr,
  output logic [DATA_W-1:0] next_pc
);
  localparam int EXT_W = DATA_W - 4;
  localparam logic [DATA_W-1:0] STEP_C = DATA_W'(PC_STEP);

  logic [DATA_W-1:0] step_ext;

  always_comb begin
    step_ext = {{EXT_W{step[3]}}, step};
    inc_addr = base + step_ext;
    if (legal && taken) next_pc = loop_addr - STEP_C;
    else                next_pc = pc + STEP_C;
  end
endmodule

// File: rtl/loopback_load_exec.sv
module loopback_load_exec
  import lbl_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic [31:0]       instr_word,
  input  logic [DATA_W-1:0] instr_pc,
  input  logic              flag_z,
  input  logic              flag_n,
  input  logic              flag_c,
  input  logic              flag_v,
  input  logic [DATA_W-1:0] loop_addr,
  input  logic [DATA_W-1:0] base_val,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [DATA_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_illegal,
  output logic              res_dst_we,
  output logic [IDX_W-1:0]  res_dst_idx,
  output logic [DATA_W-1:0] res_dst_data,
  output logic              res_base_we,
  output logic [IDX_W-1:0]  res_base_idx,
  output logic [DATA_W-1:0] res_base_data,
  output logic [DATA_W-1:0] res_next_pc
);

  st_e               state;
  dec_t              dec_in;
  dec_t              dec_q;
  flags_t            flg_in;
  logic              taken_in;
  logic [DATA_W-1:0] inc_in;
  logic [DATA_W-1:0] npc_in;
  logic [DATA_W-1:0] addr_q;
  logic [DATA_W-1:0] inc_q;
  logic [DATA_W-1:0] npc_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;

  assign flg_in = '{z: flag_z, n: flag_n, c: flag_c, v: flag_v};

  lbl_decode u_dec (
    .word (instr_word),
    .dec  (dec_in)
  );

  lbl_cond u_cond (
    .flg   (flg_in),
    .sel   (dec_in.sel),
    .taken (taken_in)
  );

  lbl_addr #(.DATA_W(DATA_W), .PC_STEP(PC_STEP)) u_addr (
    .base      (base_val),
    .step      (dec_in.step),
    .pc        (instr_pc),
    .loop_addr (loop_addr),
    .taken     (taken_in),
    .legal     (dec_in.legal),
    .inc_addr  (inc_in),
    .next_pc   (npc_in)
  );

  assign instr_ready = (state == ST_IDLE);
  assign accept      = instr_valid && instr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      dec_q  <= '0;
      addr_q <= '0;
      inc_q  <= '0;
      npc_q  <= '0;
      data_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            dec_q  <= dec_in;
            addr_q <= base_val;
            inc_q  <= inc_in;
            npc_q  <= npc_in;
            state  <= dec_in.legal ? ST_REQ : ST_DONE;
          end
        end
        ST_REQ: begin
          if (mem_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            data_q <= mem_rsp_data;
            state  <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (res_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state == ST_REQ);
  assign mem_req_addr  = addr_q;
  assign res_valid     = (state == ST_DONE);
  assign res_illegal   = !dec_q.legal;
  assign res_base_we   = res_valid && dec_q.legal;
  assign res_dst_we    = res_valid && dec_q.legal && (dec_q.dst != dec_q.base);
  assign res_dst_idx   = dec_q.dst;
  assign res_base_idx  = dec_q.base;
  assign res_dst_data  = data_q;
  assign res_base_data = inc_q;
  assign res_next_pc   = npc_q;

  // Handshake stability (R9)
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_res_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_next_pc) && $stable(res_dst_data)
                                && $stable(res_base_data));

  p_excl_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && res_valid));

  p_req_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> $past(instr_valid));

  // Illegal encodings write nothing (R1)
  p_illegal_nowr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_illegal |-> !res_dst_we && !res_base_we);

  // Aliased registers suppress the destination write (R8)
  p_alias_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_dst_we |-> res_dst_idx != res_base_idx);

endmodule

// File: tb/test_loopback_load_exec.sv
module test_loopback_load_exec;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [31:0] instr_word = '0;
  logic [31:0] instr_pc = '0;
  logic        flag_z = 0, flag_n = 0, flag_c = 0, flag_v = 0;
  logic [31:0] loop_addr = '0;
  logic [31:0] base_val = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic        res_illegal;
  logic        res_dst_we;
  logic [3:0]  res_dst_idx;
  logic [31:0] res_dst_data;
  logic        res_base_we;
  logic [3:0]  res_base_idx;
  logic [31:0] res_base_data;
  logic [31:0] res_next_pc;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #10 clk = ~clk;

  loopback_load_exec i_loopback_load_exec (
    .clk(clk), .rst_n(rst_n),
    .instr_valid(instr_valid), .instr_ready(instr_ready), .instr_word(instr_word),
    .instr_pc(instr_pc), .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v),
    .loop_addr(loop_addr), .base_val(base_val),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_illegal(res_illegal),
    .res_dst_we(res_dst_we), .res_dst_idx(res_dst_idx), .res_dst_data(res_dst_data),
    .res_base_we(res_base_we), .res_base_idx(res_base_idx), .res_base_data(res_base_data),
    .res_next_pc(res_next_pc)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference condition model: flags packed as {z,n,c,v}
  function automatic bit ref_taken(input logic [3:0] sel, input logic [3:0] f);
    bit z = f[3], n = f[2], c = f[1], v = f[0];
    bit less = (n != v);
    if (sel == 4'd0)  return less;
    if (sel == 4'd1)  return (z == 0) && !less;
    if (sel == 4'd2)  return !less;
    if (sel == 4'd3)  return z || less;
    if (sel == 4'd4)  return c;
    if (sel == 4'd5)  return !(c || z);
    if (sel == 4'd6)  return !c;
    if (sel == 4'd7)  return c || z;
    if (sel == 4'd8)  return z;
    if (sel == 4'd9)  return !z;
    if (sel == 4'd10) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check_result(input bit legal, input string pctag, input logic [3:0] rn,
                              input logic [3:0] rm, input logic [31:0] exp_pc,
                              input logic [31:0] exp_inc, input logic [31:0] exp_data);
    chk(res_valid == 1'b1, "R9", "res_valid", 32'(res_valid), 32'd1);
    chk(res_illegal == !legal, "R1", "res_illegal", 32'(res_illegal), 32'(!legal));
    chk(res_next_pc == exp_pc, pctag, "next_pc", res_next_pc, exp_pc);
    if (legal) begin
      chk(res_base_we == 1'b1 && res_base_idx == rm, "R3", "base we/idx",
          {27'd0, res_base_we, res_base_idx}, {27'd1, rm});
      chk(res_base_data == exp_inc, "R3", "base data", res_base_data, exp_inc);
      chk(res_dst_we == (rn != rm), "R8", "dst we", 32'(res_dst_we), 32'(rn != rm));
      if (rn != rm) begin
        chk(res_dst_idx == rn, "R2", "dst idx", 32'(res_dst_idx), 32'(rn));
        chk(res_dst_data == exp_data, "R2", "dst data", res_dst_data, exp_data);
      end
    end else begin
      chk(!res_dst_we && !res_base_we, "R1", "illegal write enables",
          {30'd0, res_dst_we, res_base_we}, 32'd0);
    end
  endtask

  task automatic run_op(input logic [7:0] b1, input logic [7:0] b0, input logic [3:0] rn,
                        input logic [3:0] rm, input logic [3:0] imm, input logic [3:0] sel,
                        input logic [3:0] flg, input logic [31:0] base, input logic [31:0] pc,
                        input logic [31:0] loop, input logic [31:0] data,
                        input int md, input int rd);
    bit legal = (b1 == 8'hF7) && (b0 == 8'hE0) && (sel <= 4'hA);
    bit tk = ref_taken(sel, flg);
    logic [31:0] exp_pc = (legal && tk) ? loop - 32'd4 : pc + 32'd4;
    logic [31:0] exp_inc = base + {{28{imm[3]}}, imm};
    string pctag = !legal ? "R1" : (sel < 4'd5) ? "R4" : (sel < 4'd10) ? "R5" : "R6";

    @(negedge clk);
    chk(instr_ready == 1'b1, "R9", "instr_ready idle", 32'(instr_ready), 32'd1);
    instr_valid = 1'b1;
    instr_word  = {b1, b0, rn, rm, imm, sel};
    {flag_z, flag_n, flag_c, flag_v} = flg;
    base_val = base; instr_pc = pc; loop_addr = loop;
    @(negedge clk);
    // R7: scramble sampled inputs after acceptance
    instr_valid = 1'b0;
    {flag_z, flag_n, flag_c, flag_v} = ~flg;
    base_val = ~base; instr_pc = ~pc; loop_addr = ~loop;
    chk(instr_ready == 1'b0, "R9", "busy after accept", 32'(instr_ready), 32'd0);
    if (legal) begin
      chk(mem_req_valid == 1'b1, "R2", "req valid", 32'(mem_req_valid), 32'd1);
      chk(mem_req_addr == base, "R2", "req addr", mem_req_addr, base);
      chk(res_valid == 1'b0, "R9", "no result during req", 32'(res_valid), 32'd0);
      for (int i = 0; i < md; i++) begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = (i == 0);          // R10: stray response while request stalled
        mem_rsp_data  = ~data;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        chk(mem_req_valid == 1'b1 && mem_req_addr == base, "R9", "req held",
            mem_req_addr, base);
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk(mem_req_valid == 1'b0, "R9", "req dropped", 32'(mem_req_valid), 32'd0);
      @(negedge clk);
      chk(res_valid == 1'b0, "R9", "no result before rsp", 32'(res_valid), 32'd0);
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = data;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = 32'hDEAD_0000;
    end else begin
      chk(mem_req_valid == 1'b0, "R1", "no load for illegal", 32'(mem_req_valid), 32'd0);
    end
    for (int i = 0; i < rd; i++) begin
      check_result(legal, pctag, rn, rm, exp_pc, exp_inc, data);
      @(negedge clk);
    end
    check_result(legal, pctag, rn, rm, exp_pc, exp_inc, data);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(res_valid == 1'b0 && instr_ready == 1'b1, "R9", "back to idle",
        {30'd0, res_valid, instr_ready}, 32'd1);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(instr_ready == 1'b1, "R11", "instr_ready in reset", 32'(instr_ready), 32'd1);
    chk(mem_req_valid == 1'b0, "R11", "req in reset", 32'(mem_req_valid), 32'd0);
    chk(res_valid == 1'b0, "R11", "res in reset", 32'(res_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: stray response while idle
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = 32'h1234_5678;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    @(negedge clk);
    chk(res_valid == 1'b0 && instr_ready == 1'b1, "R10", "stray rsp ignored",
        {30'd0, res_valid, instr_ready}, 32'd1);

    // R4 R5 R6 R1: every selector against every flag combination
    for (int s = 0; s < 16; s++) begin
      for (int f = 0; f < 16; f++) begin
        run_op(8'hF7, 8'hE0, 4'(f), 4'(f + s), 4'(f ^ s), 4'(s), 4'(f),
               32'h1000_0000 + 32'(f * 64 + s), 32'h0000_4000 + 32'(s * 256 + f * 4),
               32'h0000_8000 + 32'(s * 16), {8'(s), 8'(f), 16'hA5C3}, f % 3, s % 2);
      end
    end

    // R1: wrong opcode bytes
    run_op(8'hF6, 8'hE0, 4'd1, 4'd2, 4'd3, 4'hA, 4'h0, 32'h100, 32'h200, 32'h300, 32'h1, 1, 0);
    run_op(8'hF7, 8'hE1, 4'd1, 4'd2, 4'd3, 4'hA, 4'h0, 32'h100, 32'h200, 32'h300, 32'h2, 0, 1);
    // R3: negative steps
    run_op(8'hF7, 8'hE0, 4'd3, 4'd4, 4'h8, 4'h8, 4'h0, 32'h0000_0100, 32'h40, 32'h80,
           32'hCAFE_0001, 2, 2);
    run_op(8'hF7, 8'hE0, 4'd3, 4'd4, 4'hF, 4'h9, 4'h0, 32'h0000_0000, 32'h40, 32'h80,
           32'hCAFE_0002, 0, 0);
    // R8: aliased registers with positive step
    run_op(8'hF7, 8'hE0, 4'd7, 4'd7, 4'h7, 4'hA, 4'hF, 32'h2000, 32'h50, 32'h90,
           32'hBEEF_0003, 1, 1);
    // R6: zero loop address wraps
    run_op(8'hF7, 8'hE0, 4'd2, 4'd5, 4'h1, 4'hA, 4'h0, 32'h3000, 32'hFFFF_FFFC, 32'h0,
           32'hBEEF_0004, 0, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule